// File: doc/BRIEF.md
# Execute Stage: Integer ALU and Address Former with Condition Flags

This block is the execute stage of a small 16-bit processor. Each cycle it takes one instruction word and the values read from an 8-entry register file for the word's source fields. It splits the word into fields and picks the second operand, either a register value or a small constant held in the word. It then runs one of four operations and returns the result together with the destination index and a register write enable. For memory instructions it forms the effective address and raises a read or write strobe.

A four-bit status register holds negative, zero, carry and overflow flags. It is written on a clock edge only when a valid arithmetic/logic instruction asks for it through its update bit. Every other instruction leaves the flags alone. The register file storage, the memory access itself and branch resolution sit outside this block.

Top module: `exu_core`

## Requirements
- R1: Bits 15:14 select the class (00 arithmetic/logic, 01 load, 10 store, 11 branch). With `instr_valid_i` high, `rd_we_o` is 1 for classes 00 and 01 only, `mem_rd_o` is 1 for class 01 only, and `mem_wr_o` is 1 for class 10 only. With `instr_valid_i` low all three are 0.
- R2: `rd_idx_o` shows bits 13:11, `rs1_idx_o` shows bits 5:3 and `rs2_idx_o` shows bits 2:0 of the instruction.
- R3: For class 00, bits 8:7 select the operation: 00 a+b, 01 a-b, 10 bitwise AND, 11 bitwise OR. The result on `result_o` is taken modulo 2^16, with a = `rs1_val_i`.
- R4: Bit 6 set makes b the 3-bit constant in bits 2:0, zero-extended, and `rs2_val_i` is then ignored. Bit 6 clear makes b = `rs2_val_i`.
- R5: `psr_o` is {N,Z,C,V} on bits 3..0. N is the result's top bit and Z means the result is zero. For add, C is the carry out. For subtract, C is 1 when a >= b unsigned. V is two's-complement overflow of the add or subtract. AND and OR give C=0 and V=0.
- R6: On a clock edge, `psr_o` takes the flags of the current instruction only if it is valid, of class 00 and has bit 10 set. Otherwise `psr_o` keeps its value.
- R7: For classes 01 and 10, `mem_addr_o` = a + b, with b chosen by bit 6 as in R4. This holds whatever bits 8:7 and bit 10 contain, and the flags are not changed.
- R8: For a store, `mem_wdata_o` carries `store_val_i`, which is the value of the register named by bits 13:11 and shown on `rd_idx_o`, and no register write occurs.
- R9: While `rst_n` is low, `psr_o` is 0.
- R10: A branch-class word produces no register write and no memory strobe, and it leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| rs1_val_i | input | DATA_W | Value of register named by bits 5:3 |
| rs2_val_i | input | DATA_W | Value of register named by bits 2:0 |
| store_val_i | input | DATA_W | Value of register named by bits 13:11 (store data) |
| rs1_idx_o | output | 3 | First source read index |
| rs2_idx_o | output | 3 | Second source read index |
| rd_idx_o | output | 3 | Destination index, or store data index |
| rd_we_o | output | 1 | Register write enable |
| result_o | output | DATA_W | Operation result or effective address |
| mem_rd_o | output | 1 | Load strobe |
| mem_wr_o | output | 1 | Store strobe |
| mem_addr_o | output | DATA_W | Effective memory address |
| mem_wdata_o | output | DATA_W | Store data |
| psr_o | output | 4 | Status flags {N,Z,C,V} |

## Verification
The bench builds the block with the default width of 16 bits. At that width the carry and overflow edges can be driven directly with operands such as 0xFFFF, 0x7FFF and 0x8000, and a bench-side integer model sees each wrap exactly. A 3-bit constant sits against full-width register values, so immediate tests can set `rs2_val_i` to a distinctive value and show that it has no effect. Flag-hold cases are checked by updating the flags to a known non-zero value first, so that an unwanted write would show up on `psr_o`.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 3;
  localparam int IMM_W   = 3;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } instr_class_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // bit layout follows the word, top field first
  typedef struct packed {
    instr_class_e        cls;
    logic [RIDX_W-1:0]   rd;
    logic                flag_wr;
    logic                rsvd;
    alu_op_e             op;
    logic                use_imm;
    logic [RIDX_W-1:0]   rs1;
    logic [RIDX_W-1:0]   rs2;
  } instr_fields_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  output instr_fields_t      fields_o,
  output logic               is_mem_o,
  output logic               rd_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               flag_upd_o
);

  instr_fields_t f;
  logic          unused_rsvd;

  assign f           = instr_fields_t'(instr_i);
  assign fields_o    = f;
  assign unused_rsvd = f.rsvd;

  always_comb begin
    is_mem_o   = 1'b0;
    rd_we_o    = 1'b0;
    mem_rd_o   = 1'b0;
    mem_wr_o   = 1'b0;
    flag_upd_o = 1'b0;
    unique case (f.cls)
      CLS_ALU: begin
        rd_we_o    = valid_i;
        flag_upd_o = valid_i & f.flag_wr;
      end
      CLS_LOAD: begin
        is_mem_o = 1'b1;
        rd_we_o  = valid_i;
        mem_rd_o = valid_i;
      end
      CLS_STORE: begin
        is_mem_o = 1'b1;
        mem_wr_o = valid_i;
      end
      default: ;
    endcase
  end

  // R1
  always_comb begin
    if (mem_rd_o || mem_wr_o) begin
      mem_strobe_excl_chk: assert (!(mem_rd_o && mem_wr_o));
    end
  end

endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] op_b_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  assign op_b_o = use_imm_i ? zext_imm(imm_i) : reg_val_i;

  // R4
  always_comb begin
    if (use_imm_i) begin
      imm_range_chk: assert (op_b_o < (DATA_W'(1) << IMM_W));
    end
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] wide_add(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic              cin
  );
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  logic              arith;
  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_full;

  always_comb begin
    do_sub   = (op_i == OP_SUB);
    arith    = (op_i == OP_ADD) || do_sub;
    b_eff    = do_sub ? ~b_i : b_i;
    sum_full = wide_add(a_i, b_eff, do_sub);
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = sum_full[DATA_W-1:0];
    endcase
    flags_o.n = res_o[MSB];
    flags_o.z = ~|res_o;
    flags_o.c = arith & sum_full[DATA_W];
    flags_o.v = arith & signed_ovf(a_i[MSB], b_eff[MSB], res_o[MSB]);
  end

  // R3
  always_comb begin
    if (op_i == OP_SUB) begin
      sub_inverse_chk: assert (DATA_W'(res_o + b_i) == a_i);
    end
    if (op_i == OP_ADD) begin
      add_inverse_chk: assert (DATA_W'(res_o - b_i) == a_i);
    end
  end

endmodule

// File: rtl/exu_psr.sv
module exu_psr
  import exu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_i,
  input  flags_t flags_i,
  output flags_t psr_o
);

  flags_t psr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psr_q <= '0;
    else if (upd_i) psr_q <= flags_i;
  end

  assign psr_o = psr_q;

  // R6
  psr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(psr_q));

  // R6
  psr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> (psr_q == $past(flags_i)));

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid_i,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] rs1_val_i,
  input  logic [DATA_W-1:0] rs2_val_i,
  input  logic [DATA_W-1:0] store_val_i,
  output logic [2:0]        rs1_idx_o,
  output logic [2:0]        rs2_idx_o,
  output logic [2:0]        rd_idx_o,
  output logic              rd_we_o,
  output logic [DATA_W-1:0] result_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [3:0]        psr_o
);

  instr_fields_t     fields;
  logic              is_mem;
  logic              flag_upd;
  logic [DATA_W-1:0] op_b;
  logic [DATA_W-1:0] alu_res;
  alu_op_e           op_eff;
  flags_t            flags_nxt;
  flags_t            psr_q;

  exu_decode u_decode (
    .instr_i    (instr_i),
    .valid_i    (instr_valid_i),
    .fields_o   (fields),
    .is_mem_o   (is_mem),
    .rd_we_o    (rd_we_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .flag_upd_o (flag_upd)
  );

  exu_operand #(.DATA_W(DATA_W)) u_operand (
    .reg_val_i (rs2_val_i),
    .imm_i     (fields.rs2),
    .use_imm_i (fields.use_imm),
    .op_b_o    (op_b)
  );

  // memory classes always form base plus offset
  assign op_eff = is_mem ? OP_ADD : fields.op;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (rs1_val_i),
    .b_i     (op_b),
    .op_i    (op_eff),
    .res_o   (alu_res),
    .flags_o (flags_nxt)
  );

  exu_psr u_psr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (flag_upd),
    .flags_i (flags_nxt),
    .psr_o   (psr_q)
  );

  assign rs1_idx_o   = fields.rs1;
  assign rs2_idx_o   = fields.rs2;
  assign rd_idx_o    = fields.rd;
  assign result_o    = alu_res;
  assign mem_addr_o  = alu_res;
  assign mem_wdata_o = store_val_i;
  assign psr_o       = psr_q;

  // R1
  we_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (instr_valid_i && !instr_i[15]));

  // R8
  store_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> !rd_we_o);

  // R7
  addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o == DATA_W'(rs1_val_i + op_b)));

  // R10
  branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[15:14] == 2'b11) |-> (!rd_we_o && !mem_rd_o && !mem_wr_o && !flag_upd));

endmodule

// File: tb/exu_core_tb.sv
module exu_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] rs1_val_i = '0;
  logic [15:0] rs2_val_i = '0;
  logic [15:0] store_val_i = '0;
  logic [2:0]  rs1_idx_o, rs2_idx_o, rd_idx_o;
  logic        rd_we_o, mem_rd_o, mem_wr_o;
  logic [15:0] result_o, mem_addr_o, mem_wdata_o;
  logic [3:0]  psr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_psr = 4'h0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exu_core u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .store_val_i(store_val_i),
    .rs1_idx_o(rs1_idx_o), .rs2_idx_o(rs2_idx_o), .rd_idx_o(rd_idx_o),
    .rd_we_o(rd_we_o), .result_o(result_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .psr_o(psr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [1:0] cls, input logic [2:0] rd,
      input logic p, input logic [1:0] op, input logic i, input logic [2:0] s1, input logic [2:0] s2);
    return {cls, rd, p, 1'b0, op, i, s1, s2};
  endfunction

  // independent model: integer arithmetic, flags {N,Z,C,V}
  task automatic model(input int op, input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] r, output logic [3:0] fl);
    int sa, sb, sr;
    logic c, v;
    sa = int'($signed(a));
    sb = int'($signed(b));
    c = 1'b0;
    v = 1'b0;
    case (op)
      0: begin
        r = 16'((int'(a) + int'(b)) & 32'hFFFF);
        c = (int'(a) + int'(b)) > 65535;
        sr = sa + sb;
        v = (sr > 32767) || (sr < -32768);
      end
      1: begin
        r = 16'((int'(a) - int'(b)) & 32'hFFFF);
        c = a >= b;
        sr = sa - sb;
        v = (sr > 32767) || (sr < -32768);
      end
      2: r = a & b;
      default: r = a | b;
    endcase
    fl = {r[15], r == 16'h0, c, v};
  endtask

  task automatic t_alu(input string tag, input int op, input logic p, input logic imm,
                       input logic [2:0] rd, input logic [2:0] s1, input logic [2:0] s2,
                       input logic [15:0] a, input logic [15:0] breg);
    logic [15:0] r;
    logic [3:0]  fl;
    logic [15:0] b;
    b = imm ? {13'h0, s2} : breg;
    model(op, a, b, r, fl);
    @(negedge clk);
    instr_i = word(2'b00, rd, p, 2'(op), imm, s1, s2);
    rs1_val_i = a;
    rs2_val_i = breg;
    instr_valid_i = 1'b1;
    #1;
    chk({tag, " R3 result"}, 32'(result_o), 32'(r));
    chk({tag, " R1 we"}, 32'(rd_we_o), 32'd1);
    chk({tag, " R1 no mem"}, 32'({mem_rd_o, mem_wr_o}), 32'd0);
    chk({tag, " R2 idx"}, 32'({rd_idx_o, rs1_idx_o, rs2_idx_o}), 32'({rd, s1, s2}));
    if (p) exp_psr = fl;
    @(negedge clk);
    chk({tag, p ? " R5 flags" : " R6 hold"}, 32'(psr_o), 32'(exp_psr));
    instr_valid_i = 1'b0;
  endtask

  task automatic t_mem(input string tag, input logic store, input logic imm,
                       input logic [15:0] a, input logic [15:0] breg, input logic [2:0] s2);
    logic [15:0] addr;
    addr = a + (imm ? {13'h0, s2} : breg);
    @(negedge clk);
    // bits 8:7 = 11 and bit 10 = 1 must not matter
    instr_i = word(store ? 2'b10 : 2'b01, 3'd6, 1'b1, 2'b11, imm, 3'd3, s2);
    rs1_val_i = a;
    rs2_val_i = breg;
    store_val_i = 16'hA5C3;
    instr_valid_i = 1'b1;
    #1;
    chk({tag, " R7 addr"}, 32'(mem_addr_o), 32'(addr));
    chk({tag, " R1 strobes"}, 32'({mem_rd_o, mem_wr_o}), store ? 32'b01 : 32'b10);
    chk({tag, " R1 we"}, 32'(rd_we_o), store ? 32'd0 : 32'd1);
    if (store) begin
      chk({tag, " R8 wdata"}, 32'(mem_wdata_o), 32'hA5C3);
      chk({tag, " R8 data idx"}, 32'(rd_idx_o), 32'd6);
    end
    @(negedge clk);
    chk({tag, " R7 flags kept"}, 32'(psr_o), 32'(exp_psr));
    instr_valid_i = 1'b0;
  endtask

  task automatic t_branch();
    @(negedge clk);
    instr_i = {2'b11, 3'b001, 11'h003};
    rs1_val_i = 16'h0000;
    instr_valid_i = 1'b1;
    #1;
    chk("R10 no write", 32'({rd_we_o, mem_rd_o, mem_wr_o}), 32'd0);
    @(negedge clk);
    chk("R10 flags kept", 32'(psr_o), 32'(exp_psr));
    instr_valid_i = 1'b0;
  endtask

  task automatic t_invalid();
    @(negedge clk);
    instr_i = word(2'b00, 3'd1, 1'b1, 2'b01, 1'b0, 3'd2, 3'd3);
    rs1_val_i = 16'h0005;
    rs2_val_i = 16'h0005;
    instr_valid_i = 1'b0;
    #1;
    chk("R1 invalid no we", 32'({rd_we_o, mem_rd_o, mem_wr_o}), 32'd0);
    @(negedge clk);
    chk("R6 invalid keeps flags", 32'(psr_o), 32'(exp_psr));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset psr", 32'(psr_o), 32'd0);
    rst_n = 1'b1;
    t_alu("add reg",        0, 1'b1, 1'b0, 3'd1, 3'd2, 3'd3, 16'h1234, 16'h0101);
    t_alu("add carry",      0, 1'b1, 1'b0, 3'd2, 3'd0, 3'd7, 16'hFFFF, 16'h0001);
    t_alu("add ovf",        0, 1'b1, 1'b0, 3'd3, 3'd4, 3'd5, 16'h7FFF, 16'h0001);
    t_alu("sub equal",      1, 1'b1, 1'b0, 3'd1, 3'd2, 3'd3, 16'h4444, 16'h4444);
    t_alu("sub borrow",     1, 1'b1, 1'b0, 3'd1, 3'd2, 3'd3, 16'h0001, 16'h0002);
    t_alu("sub ovf",        1, 1'b1, 1'b0, 3'd7, 3'd6, 3'd1, 16'h8000, 16'h0001);
    t_alu("and",            2, 1'b1, 1'b0, 3'd5, 3'd1, 3'd2, 16'hF0F0, 16'h8F0F);
    t_alu("or",             3, 1'b1, 1'b0, 3'd4, 3'd3, 3'd0, 16'h0000, 16'h0000);
    t_alu("sub imm R4",     1, 1'b1, 1'b1, 3'd1, 3'd2, 3'd3, 16'h0003, 16'hBEEF);
    t_alu("add imm R4",     0, 1'b1, 1'b1, 3'd0, 3'd1, 3'd7, 16'hFFF9, 16'h0001);
    t_alu("set flags",      1, 1'b1, 1'b0, 3'd1, 3'd2, 3'd3, 16'h0001, 16'h0002);
    t_alu("no update",      0, 1'b0, 1'b0, 3'd1, 3'd2, 3'd3, 16'h0000, 16'h0000);
    t_invalid();
    t_mem("load reg",   1'b0, 1'b0, 16'h1000, 16'h0020, 3'd2);
    t_mem("load imm",   1'b0, 1'b1, 16'hFFFE, 16'h7777, 3'd2);
    t_mem("store reg",  1'b1, 1'b0, 16'h2000, 16'h0004, 3'd2);
    t_mem("store imm",  1'b1, 1'b1, 16'h2000, 16'h9999, 3'd5);
    t_branch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule